// File: doc/BRIEF.md
# Burst DMA Channel with Tail-Byte Mask

This block is one channel of a slave DMA engine. It moves data between memory and a fixed peripheral FIFO in bursts of 32 bytes. Software programs the channel through a small register window. It loads a burst count, the two addresses and a byte mask for the final burst, then sets the enable bit. The channel then walks the active address up by one burst per memory grant. On the final burst it drives byte enables from the mask. When the count runs out it raises a transfer-end flag and, if allowed, an interrupt.

Each burst is one request/grant handshake on the memory port. In device-to-memory mode the memory port writes what the FIFO presents and pops the FIFO. In memory-to-device mode it reads memory and pushes the FIFO. The FIFO side can report a short or null packet, which stalls the channel until software acknowledges it with a forced-end request. The FIFO side can also demand an immediate stop.

Sequencing is done by a three-state machine:
- IDLE waits for a legal start. It goes to RUN when the active address is aligned. It stays in IDLE and flags an address error when the address is misaligned.
- RUN decides the next action:
  - it returns to IDLE on enable clear, on a stop request, on a forced end or on count zero;
  - it goes to BURST when the FIFO is ready and no null event is pending.
- BURST holds the memory request until it is granted, then returns to RUN.

Top module: `burst_dma_chan`

## Requirements
- R1: After reset every register reads as zero, no memory request is made and the interrupt is low.
- R2: Register window, by byte offset: source address 0x00, destination address 0x04, burst count 0x08 (only the low 24 bits are kept), control 0x14, final-burst mask 0x18, global operation 0x1C. In the global operation register, bit 0 is master enable and bit 1 is the address error flag.
- R3: The channel starts when control bits enable (bit 0) =1, end (bit 1) =0 and stop (bit 2) =0, with master enable =1 and the address error flag =0. It then makes one memory request per burst while `fifo_rdy` is high and holds each request until granted. Each grant lowers the count by one.
- R4: Control bit 3 selects the direction.
  - With bit 3 =1 (device to memory), `mem_we` is high, `mem_addr` is the destination address, each grant adds 32 to the destination, and the source is left unchanged and ignored.
  - With bit 3 =0 (memory to device), `mem_we` is low and only the source is used and advanced.
  - Write data passes from `fifo_rdata` to `mem_wdata`.
- R5: While the count is 1, `mem_be[i]` equals final-mask bit 31-i, so the mask is left-aligned with bit 31 for the first byte. Otherwise all byte enables are one.
- R6: Reaching a zero count while running sets the end bit (bit 1). `irq` is high exactly when control bit 5 (interrupt enable) is set and the end or stop bit is set.
- R7: Writing zero to the end, stop or null bit (bit 12) clears it. Writing one never sets it.
- R8: With null-detect enable (bit 16) set, `fifo_null` while the channel is active sets the null bit. No new burst starts while the null bit is set.
- R9: A control write that clears the null bit and sets bit 24 while the null bit is set requests a forced end. The channel then ends without further bursts, sets the end bit, and bit 24 reads back zero.
- R10: Clearing enable while a burst waits for grant lets that burst complete (count and address advance once). The channel then halts without setting the end bit.
- R11: A start attempt with the active address not 32-byte aligned sets the address error flag and makes no request. Writing zero to the flag clears it.
- R12: `fifo_stop` seen in RUN sets the stop bit and halts the channel.
- R13: Writing 1 to bit 2 of the global operation register clears all channel registers and the address error flag, and loads master enable from bit 0 of the same write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory burst request |
| mem_gnt | input | 1 | Memory burst grant |
| mem_we | output | 1 | Burst is a memory write |
| mem_addr | output | 32 | Burst start address |
| mem_be | output | 32 | Byte enables for the burst |
| mem_wdata | output | 256 | Burst write data |
| mem_rdata | input | 256 | Burst read data |
| fifo_rdy | input | 1 | FIFO can supply or accept a burst |
| fifo_null | input | 1 | FIFO reports a short or null packet |
| fifo_stop | input | 1 | FIFO requests the channel to stop |
| fifo_rdata | input | 256 | Data from the FIFO |
| fifo_pop | output | 1 | FIFO data consumed |
| fifo_wdata | output | 256 | Data to the FIFO |
| fifo_push | output | 1 | FIFO data written |
| irq | output | 1 | Channel interrupt |

## Verification
The collision that matters is a null-packet report landing in the same cycle as the grant of the final burst. The count reaches zero while the null bit is being set. The bench provokes this by holding the grant off until the last request is up, then raising the grant and `fifo_null` together for one cycle. It then expects both the end and null bits set, the destination advanced once and the final mask on the byte enables. A second overlap, clearing enable while a burst waits for grant, is judged by the count and address moving exactly once with no end flag.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_BURST} bdc_state_e;

    localparam logic [4:0] OFS_SRC  = 5'h00;
    localparam logic [4:0] OFS_DST  = 5'h04;
    localparam logic [4:0] OFS_CNT  = 5'h08;
    localparam logic [4:0] OFS_CTRL = 5'h14;
    localparam logic [4:0] OFS_MASK = 5'h18;
    localparam logic [4:0] OFS_OPR  = 5'h1C;

    localparam int B_EN   = 0;
    localparam int B_END  = 1;
    localparam int B_STOP = 2;
    localparam int B_DIR  = 3;
    localparam int B_IE   = 5;
    localparam int B_TSZ  = 6;
    localparam int B_NUL  = 12;
    localparam int B_NULE = 16;
    localparam int B_FEND = 24;

    localparam int B_MEN  = 0;
    localparam int B_AERR = 1;
    localparam int B_SRST = 2;
endpackage

// File: rtl/bdc_regs.sv
module bdc_regs
    import bdc_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 24,
    parameter int BURST_BYTES = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  logic [4:0]             reg_addr,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    input  logic                   adv,
    input  logic                   end_set,
    input  logic                   stop_set,
    input  logic                   null_set,
    input  logic                   aerr_set,
    output logic [ADDR_W-1:0]      src,
    output logic [ADDR_W-1:0]      dst,
    output logic [CNT_W-1:0]       cnt,
    output logic [BURST_BYTES-1:0] mask,
    output logic                   en,
    output logic                   dir,
    output logic                   ie,
    output logic                   endf,
    output logic                   stopf,
    output logic                   nulf,
    output logic                   nule,
    output logic                   fend,
    output logic                   men,
    output logic                   aerr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BURST_BYTES);

    logic [1:0] tsz;
    logic wr_src, wr_dst, wr_cnt, wr_ctrl, wr_mask, wr_opr, srst;

    assign wr_src  = reg_we && (reg_addr == OFS_SRC);
    assign wr_dst  = reg_we && (reg_addr == OFS_DST);
    assign wr_cnt  = reg_we && (reg_addr == OFS_CNT);
    assign wr_ctrl = reg_we && (reg_addr == OFS_CTRL);
    assign wr_mask = reg_we && (reg_addr == OFS_MASK);
    assign wr_opr  = reg_we && (reg_addr == OFS_OPR);
    assign srst    = wr_opr && reg_wdata[B_SRST];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src <= '0; dst <= '0; cnt <= '0; mask <= '0;
            en <= 1'b0; dir <= 1'b0; ie <= 1'b0; tsz <= '0;
            endf <= 1'b0; stopf <= 1'b0; nulf <= 1'b0; nule <= 1'b0;
            fend <= 1'b0; men <= 1'b0; aerr <= 1'b0;
        end else if (srst) begin
            src <= '0; dst <= '0; cnt <= '0; mask <= '0;
            en <= 1'b0; dir <= 1'b0; ie <= 1'b0; tsz <= '0;
            endf <= 1'b0; stopf <= 1'b0; nulf <= 1'b0; nule <= 1'b0;
            fend <= 1'b0; aerr <= 1'b0;
            men <= reg_wdata[B_MEN];
        end else begin
            if (adv && !dir)  src <= src + STEP;
            else if (wr_src)  src <= reg_wdata[ADDR_W-1:0];
            if (adv && dir)   dst <= dst + STEP;
            else if (wr_dst)  dst <= reg_wdata[ADDR_W-1:0];
            if (adv)          cnt <= cnt - CNT_W'(1);
            else if (wr_cnt)  cnt <= reg_wdata[CNT_W-1:0];
            if (wr_mask)      mask <= reg_wdata[BURST_BYTES-1:0];
            if (end_set)      fend <= 1'b0;
            else if (wr_ctrl && nulf && !reg_wdata[B_NUL] && reg_wdata[B_FEND])
                              fend <= 1'b1;
            endf  <= (wr_ctrl ? (endf  & reg_wdata[B_END])  : endf)  | end_set;
            stopf <= (wr_ctrl ? (stopf & reg_wdata[B_STOP]) : stopf) | stop_set;
            nulf  <= (wr_ctrl ? (nulf  & reg_wdata[B_NUL])  : nulf)  | null_set;
            if (wr_ctrl) begin
                en   <= reg_wdata[B_EN];
                dir  <= reg_wdata[B_DIR];
                ie   <= reg_wdata[B_IE];
                tsz  <= reg_wdata[B_TSZ+1:B_TSZ];
                nule <= reg_wdata[B_NULE];
            end
            if (wr_opr) men <= reg_wdata[B_MEN];
            aerr <= (wr_opr ? (aerr & reg_wdata[B_AERR]) : aerr) | aerr_set;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_SRC:  reg_rdata = 32'(src);
            OFS_DST:  reg_rdata = 32'(dst);
            OFS_CNT:  reg_rdata = 32'(cnt);
            OFS_MASK: reg_rdata = 32'(mask);
            OFS_CTRL: begin
                reg_rdata[B_EN]   = en;
                reg_rdata[B_END]  = endf;
                reg_rdata[B_STOP] = stopf;
                reg_rdata[B_DIR]  = dir;
                reg_rdata[B_IE]   = ie;
                reg_rdata[B_TSZ+1:B_TSZ] = tsz;
                reg_rdata[B_NUL]  = nulf;
                reg_rdata[B_NULE] = nule;
                reg_rdata[B_FEND] = fend;
            end
            OFS_OPR: begin
                reg_rdata[B_MEN]  = men;
                reg_rdata[B_AERR] = aerr;
            end
            default: reg_rdata = '0;
        endcase
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !srst) |=> (cnt == $past(cnt) - CNT_W'(1)))
        else $error("count did not step"); // R3
    AST_FIXED_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && dir && !wr_src && !srst) |=> (src == $past(src)))
        else $error("fixed side moved"); // R4
endmodule

// File: rtl/bdc_seq.sv
module bdc_seq
    import bdc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic endf,
    input  logic stopf,
    input  logic men,
    input  logic aerr,
    input  logic nulf,
    input  logic nule,
    input  logic fend,
    input  logic cnt_zero,
    input  logic misaligned,
    input  logic fifo_rdy,
    input  logic fifo_null,
    input  logic fifo_stop,
    input  logic mem_gnt,
    output logic mem_req,
    output logic adv,
    output logic end_set,
    output logic stop_set,
    output logic null_set,
    output logic aerr_set
);
    bdc_state_e state, state_nx;
    logic start_ok;

    assign start_ok = en && !endf && !stopf && men && !aerr;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        adv      = 1'b0;
        end_set  = 1'b0;
        stop_set = 1'b0;
        aerr_set = 1'b0;
        unique case (state)
            ST_IDLE: if (start_ok) begin
                if (misaligned) aerr_set = 1'b1;
                else            state_nx = ST_RUN;
            end
            ST_RUN: begin
                if (!en) state_nx = ST_IDLE;
                else if (fifo_stop) begin
                    stop_set = 1'b1;
                    state_nx = ST_IDLE;
                end else if (fend || cnt_zero) begin
                    end_set  = 1'b1;
                    state_nx = ST_IDLE;
                end else if (!nulf && fifo_rdy) state_nx = ST_BURST;
            end
            ST_BURST: if (mem_gnt) begin
                adv      = 1'b1;
                state_nx = ST_RUN;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign mem_req  = (state == ST_BURST);
    assign null_set = (state != ST_IDLE) && nule && fifo_null;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> mem_req) else $error("request dropped"); // R3
    AST_NULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && nulf) |=> !mem_req) else $error("burst during null"); // R8
    AST_AERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && aerr) |=> (state == ST_IDLE)) else $error("start with error"); // R11
    AST_END_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        end_set |-> (cnt_zero || fend)) else $error("end without cause"); // R6
    AST_HALT_NO_END: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !en) |-> !end_set) else $error("halt set end"); // R10
endmodule

// File: rtl/burst_dma_chan.sv
module burst_dma_chan
    import bdc_pkg::*;
#(
    parameter int BURST_BYTES = 32,
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 24,
    localparam int DATA_W     = 8 * BURST_BYTES,
    localparam int OFS_W      = $clog2(BURST_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  logic [4:0]             reg_addr,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    output logic                   mem_req,
    input  logic                   mem_gnt,
    output logic                   mem_we,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [BURST_BYTES-1:0] mem_be,
    output logic [DATA_W-1:0]      mem_wdata,
    input  logic [DATA_W-1:0]      mem_rdata,
    input  logic                   fifo_rdy,
    input  logic                   fifo_null,
    input  logic                   fifo_stop,
    input  logic [DATA_W-1:0]      fifo_rdata,
    output logic                   fifo_pop,
    output logic [DATA_W-1:0]      fifo_wdata,
    output logic                   fifo_push,
    output logic                   irq
);
    logic [ADDR_W-1:0]      src, dst;
    logic [CNT_W-1:0]       cnt;
    logic [BURST_BYTES-1:0] mask;
    logic en, dir, ie, endf, stopf, nulf, nule, fend, men, aerr;
    logic adv, end_set, stop_set, null_set, aerr_set;
    logic last_burst;

    bdc_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BURST_BYTES(BURST_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .adv(adv),
        .end_set(end_set), .stop_set(stop_set), .null_set(null_set),
        .aerr_set(aerr_set), .src(src), .dst(dst), .cnt(cnt), .mask(mask),
        .en(en), .dir(dir), .ie(ie), .endf(endf), .stopf(stopf), .nulf(nulf),
        .nule(nule), .fend(fend), .men(men), .aerr(aerr)
    );

    bdc_seq u_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .endf(endf), .stopf(stopf),
        .men(men), .aerr(aerr), .nulf(nulf), .nule(nule), .fend(fend),
        .cnt_zero(cnt == '0), .misaligned(|mem_addr[OFS_W-1:0]),
        .fifo_rdy(fifo_rdy), .fifo_null(fifo_null), .fifo_stop(fifo_stop),
        .mem_gnt(mem_gnt), .mem_req(mem_req), .adv(adv), .end_set(end_set),
        .stop_set(stop_set), .null_set(null_set), .aerr_set(aerr_set)
    );

    assign mem_addr   = dir ? dst : src;
    assign mem_we     = dir;
    assign last_burst = (cnt == CNT_W'(1));

    for (genvar g = 0; g < BURST_BYTES; g++) begin : g_be
        assign mem_be[g] = last_burst ? mask[BURST_BYTES-1-g] : 1'b1;
    end

    assign mem_wdata  = fifo_rdata;
    assign fifo_wdata = mem_rdata;
    assign fifo_pop   = mem_req && mem_gnt && dir;
    assign fifo_push  = mem_req && mem_gnt && !dir;
    assign irq        = ie && (endf || stopf);

    AST_BE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && cnt > CNT_W'(1)) |-> (&mem_be)) else $error("partial be early"); // R5
    AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_pop && fifo_push)) else $error("both sides strobed"); // R4
endmodule

// File: tb/sim_burst_dma_chan.sv
module sim_burst_dma_chan;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic mem_req, mem_we, fifo_pop, fifo_push, irq;
    logic gnt_en = 1'b1;
    logic mem_gnt;
    logic [31:0] mem_addr, mem_be;
    logic [255:0] mem_wdata, fifo_wdata;
    logic [255:0] mem_rdata  = {8{32'hA5A5_0F0F}};
    logic [255:0] fifo_rdata = {8{32'h1234_5678}};
    logic fifo_rdy = 1'b0, fifo_null = 1'b0, fifo_stop = 1'b0;
    int n_vec = 0, n_fail = 0;
    logic [31:0] be_log[$];

    always #5 clk = ~clk;
    assign mem_gnt = mem_req && gnt_en;

    burst_dma_chan u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .fifo_rdy(fifo_rdy),
        .fifo_null(fifo_null), .fifo_stop(fifo_stop), .fifo_rdata(fifo_rdata),
        .fifo_pop(fifo_pop), .fifo_wdata(fifo_wdata), .fifo_push(fifo_push),
        .irq(irq)
    );

    // behavioural reference model
    logic [31:0] m_src, m_dst, m_mask;
    logic [23:0] m_cnt;
    logic m_en, m_dir, m_ie, m_end, m_stop, m_nul, m_nule, m_fend, m_men, m_aerr;
    int m_ph;

    always @(posedge clk) begin : model
        bit g, es, ss, ns, as, adv, wc;
        int nph;
        logic [31:0] aa;
        if (!rst_n) begin
            m_src = 0; m_dst = 0; m_mask = 0; m_cnt = 0; m_en = 0; m_dir = 0;
            m_ie = 0; m_end = 0; m_stop = 0; m_nul = 0; m_nule = 0; m_fend = 0;
            m_men = 0; m_aerr = 0; m_ph = 0;
        end else begin
            g = (m_ph == 2) && gnt_en;
            es = 0; ss = 0; as = 0; adv = 0; nph = m_ph;
            aa = m_dir ? m_dst : m_src;
            if (m_ph == 0) begin
                if (m_en && !m_end && !m_stop && m_men && !m_aerr) begin
                    if (aa[4:0] != 0) as = 1; else nph = 1;
                end
            end else if (m_ph == 1) begin
                if (!m_en) nph = 0;
                else if (fifo_stop) begin ss = 1; nph = 0; end
                else if (m_fend || m_cnt == 0) begin es = 1; nph = 0; end
                else if (!m_nul && fifo_rdy) nph = 2;
            end else if (g) begin
                adv = 1; nph = 1;
            end
            ns = (m_ph != 0) && m_nule && fifo_null;
            wc = reg_we && reg_addr == 5'h14;
            if (reg_we && reg_addr == 5'h1C && reg_wdata[2]) begin
                m_src = 0; m_dst = 0; m_mask = 0; m_cnt = 0; m_en = 0; m_dir = 0;
                m_ie = 0; m_end = 0; m_stop = 0; m_nul = 0; m_nule = 0; m_fend = 0;
                m_aerr = 0; m_men = reg_wdata[0];
            end else begin
                if (adv && !m_dir) m_src = m_src + 32;
                else if (reg_we && reg_addr == 5'h00) m_src = reg_wdata;
                if (adv && m_dir) m_dst = m_dst + 32;
                else if (reg_we && reg_addr == 5'h04) m_dst = reg_wdata;
                if (adv) m_cnt = m_cnt - 1;
                else if (reg_we && reg_addr == 5'h08) m_cnt = reg_wdata[23:0];
                if (reg_we && reg_addr == 5'h18) m_mask = reg_wdata;
                if (es) m_fend = 0;
                else if (wc && m_nul && !reg_wdata[12] && reg_wdata[24]) m_fend = 1;
                m_end  = (wc ? (m_end  & reg_wdata[1])  : m_end)  | es;
                m_stop = (wc ? (m_stop & reg_wdata[2])  : m_stop) | ss;
                m_nul  = (wc ? (m_nul  & reg_wdata[12]) : m_nul)  | ns;
                if (wc) begin
                    m_en = reg_wdata[0]; m_dir = reg_wdata[3];
                    m_ie = reg_wdata[5]; m_nule = reg_wdata[16];
                end
                if (reg_we && reg_addr == 5'h1C) m_men = reg_wdata[0];
                m_aerr = ((reg_we && reg_addr == 5'h1C) ? (m_aerr & reg_wdata[1]) : m_aerr) | as;
            end
            m_ph = nph;
        end
    end

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic [31:0] ebe;
            for (int i = 0; i < 32; i++) ebe[i] = (m_cnt == 1) ? m_mask[31-i] : 1'b1;
            cmp("R3 mem_req", {31'b0, mem_req}, {31'b0, m_ph == 2});
            cmp("R4 mem_addr", mem_addr, m_dir ? m_dst : m_src);
            cmp("R4 mem_we", {31'b0, mem_we}, {31'b0, m_dir});
            cmp("R5 mem_be", mem_be, ebe);
            cmp("R6 irq", {31'b0, irq}, {31'b0, m_ie && (m_end || m_stop)});
            if (mem_req && gnt_en) be_log.push_back(mem_be);
        end
    end

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, logic [31:0] exp, string tag);
        reg_addr = a;
        #1;
        cmp(tag, reg_rdata, exp);
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 200 && !irq; i++) @(negedge clk);
    endtask

    task automatic wait_req();
        for (int i = 0; i < 200 && !mem_req; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(5'h14, 32'h0, "R1 ctrl");
        rd(5'h08, 32'h0, "R1 count");
        rd(5'h1C, 32'h0, "R1 opr");
        cmp("R1 irq", {31'b0, irq}, 32'h0);

        // R2 register window, memory-to-device transfer of 3 bursts
        wr(5'h1C, 32'h1);
        wr(5'h00, 32'h0000_1000);
        wr(5'h04, 32'h0000_0055);
        wr(5'h08, 32'hFF00_0003);
        wr(5'h18, 32'hFFFF_0000);
        rd(5'h08, 32'h3, "R2 count keeps 24 bits");
        rd(5'h18, 32'hFFFF_0000, "R2 mask");
        rd(5'h1C, 32'h1, "R2 opr");
        fifo_rdy = 1'b1;
        be_log.delete();
        wr(5'h14, 32'h0000_00A1);
        wait_irq();
        @(negedge clk);
        rd(5'h00, 32'h0000_1060, "R4 source advanced");
        rd(5'h04, 32'h0000_0055, "R4 destination ignored");
        rd(5'h08, 32'h0, "R3 count down");
        rd(5'h14, 32'h0000_00A3, "R6 end set");
        cmp("R6 irq", {31'b0, irq}, 32'h1);
        cmp("R3 burst count", be_log.size(), 3);
        if (be_log.size() == 3) begin
            cmp("R5 full be", be_log[0], 32'hFFFF_FFFF);
            cmp("R5 last be", be_log[2], 32'h0000_FFFF);
        end
        // R7 clear by zero, one does not set
        wr(5'h14, 32'h0);
        rd(5'h14, 32'h0, "R7 cleared");
        cmp("R7 irq low", {31'b0, irq}, 32'h0);
        wr(5'h14, 32'h0000_1006);
        rd(5'h14, 32'h0, "R7 one does not set");

        // R8/R9 device-to-memory with null event and forced end
        wr(5'h00, 32'h0000_0033);
        wr(5'h04, 32'h0000_2000);
        wr(5'h08, 32'h2);
        wr(5'h18, 32'hFFFF_FFFF);
        wr(5'h14, 32'h0001_0029);
        cmp("R4 data path", mem_wdata[31:0], fifo_rdata[31:0]);
        for (int i = 0; i < 200; i++) begin
            reg_addr = 5'h08; #1;
            if (reg_rdata == 32'h1) break;
            @(negedge clk);
        end
        fifo_rdy = 1'b0; fifo_null = 1'b1;
        @(negedge clk);
        fifo_null = 1'b0; fifo_rdy = 1'b1;
        repeat (4) @(negedge clk);
        rd(5'h08, 32'h1, "R8 stalled");
        rd(5'h14, 32'h0001_1029, "R8 null set");
        rd(5'h04, 32'h0000_2020, "R4 destination advanced");
        rd(5'h00, 32'h0000_0033, "R4 source ignored");
        wr(5'h14, 32'h0101_0029);
        wait_irq();
        @(negedge clk);
        rd(5'h14, 32'h0001_002B, "R9 forced end");
        rd(5'h08, 32'h1, "R9 no more bursts");
        wr(5'h14, 32'h0);

        // R10 enable cleared while burst waits for grant
        wr(5'h00, 32'h0000_4000);
        wr(5'h08, 32'h4);
        gnt_en = 1'b0;
        wr(5'h14, 32'h1);
        wait_req();
        wr(5'h14, 32'h0);
        gnt_en = 1'b1;
        repeat (6) @(negedge clk);
        rd(5'h08, 32'h3, "R10 burst finished");
        rd(5'h00, 32'h0000_4020, "R10 address once");
        rd(5'h14, 32'h0, "R10 no end");
        cmp("R10 idle", {31'b0, mem_req}, 32'h0);

        // R11 misaligned start
        wr(5'h00, 32'h0000_1004);
        wr(5'h08, 32'h1);
        wr(5'h14, 32'h1);
        repeat (4) @(negedge clk);
        rd(5'h1C, 32'h3, "R11 address error");
        rd(5'h08, 32'h1, "R11 no transfer");
        wr(5'h14, 32'h0);
        wr(5'h1C, 32'h1);
        rd(5'h1C, 32'h1, "R11 cleared");

        // R12 stop from FIFO
        wr(5'h00, 32'h0000_3000);
        wr(5'h08, 32'h8);
        wr(5'h14, 32'h21);
        repeat (3) @(negedge clk);
        fifo_stop = 1'b1;
        repeat (2) @(negedge clk);
        fifo_stop = 1'b0;
        repeat (2) @(negedge clk);
        rd(5'h14, 32'h25, "R12 stop set");
        cmp("R12 irq", {31'b0, irq}, 32'h1);
        wr(5'h14, 32'h0);
        cmp("R7 stop cleared", {31'b0, irq}, 32'h0);

        // null report in the same cycle as the last grant
        wr(5'h04, 32'h0000_5000);
        wr(5'h08, 32'h1);
        wr(5'h18, 32'hC000_0000);
        gnt_en = 1'b0;
        be_log.delete();
        wr(5'h14, 32'h0001_0009);
        wait_req();
        gnt_en = 1'b1; fifo_null = 1'b1;
        @(negedge clk);
        fifo_null = 1'b0;
        repeat (3) @(negedge clk);
        rd(5'h14, 32'h0001_100B, "R6 R8 end and null together");
        rd(5'h04, 32'h0000_5020, "R4 one advance");
        rd(5'h08, 32'h0, "R3 count zero");
        if (be_log.size() > 0) cmp("R5 tail two bytes", be_log[0], 32'h0000_0003);
        else cmp("R5 tail burst seen", 32'h0, 32'h1);
        wr(5'h14, 32'h0);

        // R13 soft reset
        wr(5'h1C, 32'h5);
        rd(5'h00, 32'h0, "R13 source");
        rd(5'h04, 32'h0, "R13 destination");
        rd(5'h18, 32'h0, "R13 mask");
        rd(5'h1C, 32'h1, "R13 master enable kept");

        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule